// File: doc/BRIEF.md
# Round-Synchronized Pin Stage for an Eight-Thread Barrel Pipeline

This block sits at the pin boundary of one execution pipeline that runs eight hardware threads in a fixed rotation. Every clock cycle belongs to one thread slot. Eight consecutive slots make a round, and in a round every thread retires exactly one instruction. The stage quantizes all pin traffic to whole rounds. The pins are sampled once, at the boundary that opens a round, and every thread reads that one frozen copy. Output writes made by the threads during the round are gathered in a staging register. They reach the pins together, on the edge that retires the last slot.

Seen from outside, pin timing cannot be told apart from eight separate processors, each running at one eighth of the clock rate. The instruction datapath is not part of this block. It is represented by a write port that carries an enable, a bit mask and data for whichever slot is current. A read port returns the round's input copy. The current slot number and a round-start flag are brought out so that the issuing logic knows which thread owns the cycle.

Top module: `rr_io_stage`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `pin_out` is 0, `rd_data` is 0, `cur_slot` is 0 and `round_start` is 1.
- R2: `cur_slot` advances by one on every clock edge, goes from 7 back to 0, and `round_start` is 1 exactly in the cycles where `cur_slot` is 0.
- R3: `rd_data` takes the value that `pin_in` had at the clock edge that ends slot 7, and it holds that value through all eight slots of the following round.
- R4: A change of `pin_in` during slots 0 to 6 of a round is never visible on `rd_data` within that same round.
- R5: `pin_out` changes only on the clock edge that ends slot 7. All writes accepted during that round appear on that single edge.
- R6: A write changes only the bits where `wr_mask` is 1. Bits that no thread targets keep the value they had after the previous round.
- R7: When two or more slots in one round write the same bit, the value from the slot with the higher number is the one that appears on the pin.
- R8: A cycle with `wr_en` = 0 has no effect on any later `pin_out` value, whatever `wr_mask` and `wr_data` carry.
- R9: A single thread that writes the opposite value on each of its turns toggles its pin once per round, and the pin holds each level for exactly eight cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 8 | External input pins |
| pin_out | output | 8 | External output pins, updated at round end |
| cur_slot | output | 3 | Thread slot that owns the current cycle |
| round_start | output | 1 | High in slot 0 |
| wr_en | input | 1 | Current slot writes the output pins |
| wr_mask | input | 8 | Bits targeted by the write |
| wr_data | input | 8 | Values for the targeted bits |
| rd_data | output | 8 | Input snapshot for the current round |

## Verification
A slot counter that skips or sticks shows at once on `cur_slot` and `round_start`. Within at most one round it also shows as a commit or capture edge in the wrong cycle. A staging register that loses a write, or lets a lower slot override a higher one, shows up on `pin_out` at the next round boundary, eight cycles after the write at most. A snapshot loaded in the wrong cycle shows as `rd_data` following a mid-round change of `pin_in` within the same round.

// File: rtl/rr_io_pkg.sv
package rr_io_pkg;
  localparam int NUM_THREADS = 8;
  localparam int PIN_W       = 8;
  localparam int SLOT_W      = $clog2(NUM_THREADS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_THREADS - 1);

  typedef logic [PIN_W-1:0]  pin_t;
  typedef logic [SLOT_W-1:0] slot_t;

  // Masked merge: targeted bits take new data, the rest keep cur.
  function automatic pin_t apply_write(pin_t cur, pin_t data, pin_t mask);
    return (cur & ~mask) | (data & mask);
  endfunction
endpackage

// File: rtl/rr_slot_seq.sv
module rr_slot_seq
  import rr_io_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output slot_t slot,
  output logic  round_end
);
  slot_t slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                slot_q <= '0;
    else if (slot_q == LAST_SLOT) slot_q <= '0;
    else                       slot_q <= slot_q + 1'b1;
  end

  assign slot      = slot_q;
  assign round_end = (slot_q == LAST_SLOT);

  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_end |=> (slot == '0));
  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !round_end |=> (slot == SLOT_W'($past(slot) + 1'b1)));
endmodule

// File: rtl/rr_in_snap.sv
module rr_in_snap
  import rr_io_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  pin_t pins,
  output pin_t snap
);
  pin_t snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       snap_q <= '0;
    else if (capture) snap_q <= pins;
  end

  assign snap = snap_q;

  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(snap));
  // R3
  snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (snap == $past(pins)));
endmodule

// File: rtl/rr_out_merge.sv
module rr_out_merge
  import rr_io_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic wr_en,
  input  pin_t wr_mask,
  input  pin_t wr_data,
  output pin_t pins
);
  pin_t stage_q;
  pin_t out_q;
  pin_t merged;

  always_comb begin
    merged = stage_q;
    if (wr_en) merged = apply_write(stage_q, wr_data, wr_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      stage_q <= merged;
      if (commit) out_q <= merged;
    end
  end

  assign pins = out_q;

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(pins));
  // R8
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (stage_q == $past(stage_q)));
  // R6
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_en) |=> ((pins & ~$past(wr_mask)) == ($past(stage_q) & ~$past(wr_mask))));
endmodule

// File: rtl/rr_io_stage.sv
module rr_io_stage
  import rr_io_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              round_start,
  input  logic              wr_en,
  input  logic [PIN_W-1:0]  wr_mask,
  input  logic [PIN_W-1:0]  wr_data,
  output logic [PIN_W-1:0]  rd_data
);
  slot_t slot_w;
  logic  round_end_w;

  rr_slot_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (slot_w),
    .round_end (round_end_w)
  );

  rr_in_snap u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (round_end_w),
    .pins    (pin_in),
    .snap    (rd_data)
  );

  rr_out_merge u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (round_end_w),
    .wr_en   (wr_en),
    .wr_mask (wr_mask),
    .wr_data (wr_data),
    .pins    (pin_out)
  );

  assign cur_slot    = slot_w;
  assign round_start = (slot_w == '0);

  // R5: pins and snapshot move on the same edge only
  pin_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out) |-> ($past(cur_slot) == LAST_SLOT));
  // R2
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_start |=> !round_start);
endmodule

// File: tb/tb_rr_io_stage.sv
module tb_rr_io_stage;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [2:0] cur_slot;
  logic       round_start;
  logic       wr_en = 1'b0;
  logic [7:0] wr_mask = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic       r_en   [8];
  logic [7:0] r_mask [8];
  logic [7:0] r_data [8];
  logic [7:0] exp_out = '0;

  always #5 clk = ~clk;

  rr_io_stage dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out),
    .cur_slot(cur_slot), .round_start(round_start), .wr_en(wr_en),
    .wr_mask(wr_mask), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic align;
    @(negedge clk);
    while (cur_slot != 3'd0) @(negedge clk);
  endtask

  task automatic clear_round;
    for (int s = 0; s < 8; s++) begin
      r_en[s] = 1'b0; r_mask[s] = '0; r_data[s] = '0;
    end
  endtask

  // Plays one round from slot 0; checks pins hold, then the new value.
  task automatic run_round(string req);
    logic [7:0] nxt;
    bit held = 1;
    align();
    for (int s = 0; s < 8; s++) begin
      wr_en = r_en[s]; wr_mask = r_mask[s]; wr_data = r_data[s];
      if (pin_out !== exp_out) held = 0;
      @(negedge clk);
    end
    wr_en = 1'b0; wr_mask = '0; wr_data = '0;
    nxt = exp_out;
    for (int b = 0; b < 8; b++)
      for (int s = 0; s < 8; s++)
        if (r_en[s] && r_mask[s][b]) nxt[b] = r_data[s][b];
    check("R5 pins held mid-round", {31'd0, held}, 32'd1);
    exp_out = nxt;
    check(req, pin_out, exp_out);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 pin_out", pin_out, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 slot", cur_slot, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 slot after release", cur_slot, 1);
  endtask

  task automatic t_counter;
    bit ok = 1;
    align();
    for (int i = 0; i < 20; i++) begin
      if (cur_slot !== 3'(i % 8)) ok = 0;
      if (round_start !== (i % 8 == 0)) ok = 0;
      @(negedge clk);
    end
    check("R2 slot sequence and round_start", {31'd0, ok}, 32'd1);
  endtask

  task automatic t_mask;
    clear_round();
    r_en[2] = 1; r_mask[2] = 8'h0F; r_data[2] = 8'hA5;
    r_en[5] = 1; r_mask[5] = 8'h30; r_data[5] = 8'hFF;
    run_round("R4 R6 round commit masked");
    clear_round();
    r_en[0] = 1; r_mask[0] = 8'h01; r_data[0] = 8'h00;
    run_round("R6 unmasked bits kept");
  endtask

  task automatic t_priority;
    clear_round();
    r_en[1] = 1; r_mask[1] = 8'hFF; r_data[1] = 8'h3C;
    r_en[6] = 1; r_mask[6] = 8'h0F; r_data[6] = 8'h0A;
    r_en[7] = 1; r_mask[7] = 8'h03; r_data[7] = 8'h01;
    run_round("R7 later slot wins");
    check("R7 explicit value", pin_out, 8'h39);
  endtask

  task automatic t_disabled;
    clear_round();
    for (int s = 0; s < 8; s++) begin
      r_en[s] = 0; r_mask[s] = 8'hFF; r_data[s] = ~exp_out;
    end
    run_round("R8 disabled writes ignored");
    clear_round();
    r_en[4] = 0; r_mask[4] = 8'hFF; r_data[4] = 8'h00;
    r_en[3] = 1; r_mask[3] = 8'h80; r_data[3] = 8'h80;
    run_round("R8 only enabled slot applies");
  endtask

  task automatic t_toggle;
    logic [7:0] lvl;
    int hold;
    for (int k = 0; k < 3; k++) begin
      clear_round();
      r_en[3] = 1; r_mask[3] = 8'h40; r_data[3] = ~exp_out & 8'h40;
      run_round("R9 toggle each round");
    end
    lvl = pin_out;
    hold = 0;
    clear_round();
    r_en[3] = 1; r_mask[3] = 8'h40; r_data[3] = ~exp_out & 8'h40;
    align();
    for (int s = 0; s < 8; s++) begin
      wr_en = r_en[s]; wr_mask = r_mask[s]; wr_data = r_data[s];
      if (pin_out === lvl) hold++;
      @(negedge clk);
    end
    wr_en = 1'b0; wr_mask = '0; wr_data = '0;
    exp_out = exp_out ^ 8'h40;
    check("R9 level held eight cycles", hold, 8);
    check("R9 toggled at boundary", pin_out, exp_out);
  endtask

  task automatic t_snapshot;
    logic [7:0] base;
    bit ok = 1;
    align();
    base = rd_data;
    for (int s = 0; s < 8; s++) begin
      if (s == 3) pin_in = 8'h5A;
      if (s == 7) pin_in = 8'hC3;
      if (rd_data !== base) ok = 0;
      @(negedge clk);
    end
    check("R4 mid-round input invisible", {31'd0, ok}, 32'd1);
    check("R3 captured at slot 7 edge", rd_data, 8'hC3);
    ok = 1;
    for (int s = 0; s < 7; s++) begin
      pin_in = 8'(s * 17 + 1);
      if (rd_data !== 8'hC3) ok = 0;
      @(negedge clk);
    end
    if (rd_data !== 8'hC3) ok = 0;
    check("R3 snapshot held whole round", {31'd0, ok}, 32'd1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_counter();
    t_mask();
    t_priority();
    t_disabled();
    t_toggle();
    t_snapshot();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule